// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache

This block is a read-only cache that sits between a requester and a slower backing memory. Each request carries a 32-bit byte address. The cache treats one 32-bit word as a block. The address selects one of 256 sets, and the block may live in any of the four ways of that set. The cache reads all four ways of the selected set at once and compares their tags in parallel. The way that matches drives a 4-to-1 multiplexer, which supplies the returned word. Because of this, the data is ready only after the hit decision is made.

On a miss, the cache issues one word-aligned read to the backing memory. It returns the fetched word and stores it in the set. The fill goes to the lowest-numbered invalid way if there is one. Otherwise it replaces the way that has gone unused the longest, using a true LRU age order kept for each set. Requests use a valid/ready handshake, and only one request is in flight at a time.

Top module: `cache_sa4`

## Requirements
- R1: The address splits as tag = bits [31:10], set = bits [9:2], and bits [1:0] are ignored. Addresses that differ only in bits [1:0] return the same word. A change in bit 10 or above selects a different block in the same set. A change in bits [9:2] selects a different set.
- R2: A hit returns the stored word with rsp_valid high in the first cycle after the request is accepted, and issues no backing-memory read.
- R3: A miss issues exactly one backing read, with mem_req_addr = {req_addr[31:2], 2'b00}. The response carries mem_rsp_data and is raised in the same cycle that mem_rsp_valid arrives.
- R4: Four distinct blocks that map to one set are all held at the same time. After filling them, all four hit.
- R5: A miss in a full set evicts the least recently used way. Both hits and fills count as uses. Fills take invalid ways first, in order from way 0 upward.
- R6: Two blocks that map to the same set, accessed alternately, miss only on their first two accesses.
- R7: Fills and evictions in one set do not disturb the blocks held in any other set.
- R8: req_ready is high only when no request is in flight. It stays low from acceptance until the response cycle, and it is never high in the same cycle as rsp_valid.
- R9: While mem_req_valid is high and mem_req_ready is low, mem_req_valid stays high and mem_req_addr stays unchanged.
- R10: At most one way of a set matches any lookup, so every revisited block returns its own word.
- R11: After reset all ways are invalid, req_ready is high, and rsp_valid and mem_req_valid are low. The first access to any address misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | 32 | Byte address of the read |
| rsp_valid | output | 1 | Response word valid (one cycle) |
| rsp_data | output | 32 | Response word |
| mem_req_valid | output | 1 | Backing read request |
| mem_req_ready | input | 1 | Backing memory accepts the request |
| mem_req_addr | output | 32 | Word-aligned backing read address |
| mem_rsp_valid | input | 1 | Backing read data valid |
| mem_rsp_data | input | 32 | Backing read data |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 256 sets and four ways. Because of this, the real tag/set boundary at bit 10 and the set/offset boundary at bit 2 are exercised directly, along with the full four-entry age order. The bench's backing-memory model varies its response latency and stalls mem_req_ready for several cycles. This covers both a held backing request and a fill whose data arrives late.

// File: rtl/cache_sa_pkg.sv
`timescale 1ns/1ps
package cache_sa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FETCH  = 2'd2,
        ST_FILL   = 2'd3
    } ctrl_state_e;

endpackage

// File: rtl/cache_way_store.sv
`timescale 1ns/1ps
// Tag, valid and data arrays, one bank per way. All ways are read at the
// same set index; a single way is written on a fill.
module cache_way_store #(
    parameter int SET_W  = 8,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32,
    localparam int SETS  = 1 << SET_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tags,
    output logic [WAYS-1:0]              rd_valid,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_data,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [DATA_W-1:0]            wr_data
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0]  tag_arr [SETS];
        logic [DATA_W-1:0] dat_arr [SETS];
        logic [SETS-1:0]   vld_q;
        logic              sel_wr;

        assign sel_wr = wr_en && (wr_way == WAY_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= '0;
            end else if (sel_wr) begin
                vld_q[wr_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel_wr) begin
                tag_arr[wr_set] <= wr_tag;
                dat_arr[wr_set] <= wr_data;
            end
        end

        assign rd_tags[w]  = tag_arr[rd_set];
        assign rd_data[w]  = dat_arr[rd_set];
        assign rd_valid[w] = vld_q[rd_set];
    end

endmodule

// File: rtl/cache_tag_match.sv
`timescale 1ns/1ps
// Parallel tag comparison, one comparator per way, followed by the
// hit-way encoder and the way-select multiplexer for the data.
module cache_tag_match #(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [TAG_W-1:0]             lookup_tag,
    input  logic [WAYS-1:0][TAG_W-1:0]   way_tags,
    input  logic [WAYS-1:0]              way_valid,
    input  logic [WAYS-1:0][DATA_W-1:0]  way_data,
    output logic [WAYS-1:0]              match_vec,
    output logic                         hit,
    output logic [WAY_W-1:0]             hit_way,
    output logic [DATA_W-1:0]            hit_data
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_vec[w] = way_valid[w] && (way_tags[w] == lookup_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_vec[w]) begin
                hit_way = hit_way | WAY_W'(w);
            end
        end
    end

    assign hit      = |match_vec;
    assign hit_data = way_data[hit_way];

endmodule

// File: rtl/cache_lru_age.sv
`timescale 1ns/1ps
// Per-set true-LRU state: each way holds an age, 0 = most recent,
// WAYS-1 = least recent. Ages of a set always form a permutation.
module cache_lru_age #(
    parameter int SET_W  = 8,
    parameter int WAYS   = 4,
    localparam int SETS  = 1 << SET_W,
    localparam int WAY_W = $clog2(WAYS),
    localparam int AGE_W = WAY_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SET_W-1:0]              set_idx,
    input  logic [WAYS-1:0]               set_valid,
    input  logic                          ref_en,
    input  logic [WAY_W-1:0]              ref_way,
    output logic [WAY_W-1:0]              victim_way,
    output logic [WAYS-1:0][AGE_W-1:0]    set_ages
);

    logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];
    logic [WAYS-1:0][AGE_W-1:0] ages_d;
    logic [AGE_W-1:0]           ref_age;
    logic                       free_found;

    assign set_ages = age_q[set_idx];
    assign ref_age  = set_ages[ref_way];

    // Next ages for the referenced set
    always_comb begin
        ages_d = set_ages;
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == ref_way) begin
                ages_d[w] = '0;
            end else if (set_ages[w] < ref_age) begin
                ages_d[w] = set_ages[w] + AGE_W'(1);
            end
        end
    end

    // Victim: lowest invalid way, else the oldest way
    always_comb begin
        victim_way = '0;
        free_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!set_valid[w] && !free_found) begin
                victim_way = WAY_W'(w);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (set_ages[w] == AGE_W'(WAYS - 1)) begin
                    victim_way = WAY_W'(w);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else if (ref_en) begin
            age_q[set_idx] <= ages_d;
        end
    end

endmodule

// File: rtl/cache_sa4.sv
`timescale 1ns/1ps
// Top: request handshake, lookup, miss fetch and refill control.
module cache_sa4 #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SET_W  = 8,
    parameter int WAYS   = 4,
    parameter int OFS_W  = 2,
    localparam int BLK_W = ADDR_W - OFS_W,
    localparam int TAG_W = ADDR_W - SET_W - OFS_W,
    localparam int WAY_W = $clog2(WAYS),
    localparam int AGE_W = WAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    import cache_sa_pkg::*;

    typedef struct packed {
        ctrl_state_e      state;
        logic [BLK_W-1:0] blk;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [SET_W-1:0]            cur_set;
    logic [TAG_W-1:0]            cur_tag;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tags;
    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0][DATA_W-1:0] rd_data;
    logic [WAYS-1:0]             match_vec;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way;
    logic [DATA_W-1:0]           hit_data;
    logic [WAY_W-1:0]            victim_way;
    logic [WAYS-1:0][AGE_W-1:0]  set_ages;
    logic                        fill_en;
    logic                        ref_en;
    logic [WAY_W-1:0]            ref_way;
    ctrl_state_e                 cur_state;
    logic                        unused_ofs;

    assign cur_set   = ctrl_q.blk[SET_W-1:0];
    assign cur_tag   = ctrl_q.blk[BLK_W-1 -: TAG_W];
    assign cur_state = ctrl_q.state;
    assign unused_ofs = ^req_addr[OFS_W-1:0];

    cache_way_store #(
        .SET_W (SET_W),
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (cur_set),
        .rd_tags (rd_tags),
        .rd_valid(rd_valid),
        .rd_data (rd_data),
        .wr_en   (fill_en),
        .wr_set  (cur_set),
        .wr_way  (victim_way),
        .wr_tag  (cur_tag),
        .wr_data (mem_rsp_data)
    );

    cache_tag_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_match (
        .lookup_tag(cur_tag),
        .way_tags  (rd_tags),
        .way_valid (rd_valid),
        .way_data  (rd_data),
        .match_vec (match_vec),
        .hit       (hit),
        .hit_way   (hit_way),
        .hit_data  (hit_data)
    );

    cache_lru_age #(
        .SET_W(SET_W),
        .WAYS (WAYS)
    ) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_idx   (cur_set),
        .set_valid (rd_valid),
        .ref_en    (ref_en),
        .ref_way   (ref_way),
        .victim_way(victim_way),
        .set_ages  (set_ages)
    );

    assign mem_req_addr = {ctrl_q.blk, {OFS_W{1'b0}}};

    always_comb begin
        ctrl_d        = ctrl_q;
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        rsp_data      = hit_data;
        mem_req_valid = 1'b0;
        fill_en       = 1'b0;
        ref_en        = 1'b0;
        ref_way       = hit_way;
        case (ctrl_q.state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    ctrl_d.blk   = req_addr[ADDR_W-1:OFS_W];
                    ctrl_d.state = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (hit) begin
                    rsp_valid    = 1'b1;
                    ref_en       = 1'b1;
                    ctrl_d.state = ST_IDLE;
                end else begin
                    ctrl_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    ctrl_d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_rsp_valid) begin
                    rsp_valid    = 1'b1;
                    rsp_data     = mem_rsp_data;
                    fill_en      = 1'b1;
                    ref_en       = 1'b1;
                    ref_way      = victim_way;
                    ctrl_d.state = ST_IDLE;
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, blk: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/cache_sa4_chk.sv
`timescale 1ns/1ps
module cache_sa4_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WAYS   = 4,
    parameter int AGE_W  = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_ready,
    input logic                         rsp_valid,
    input logic [DATA_W-1:0]            rsp_data,
    input logic                         mem_req_valid,
    input logic                         mem_req_ready,
    input logic [ADDR_W-1:0]            mem_req_addr,
    input logic                         mem_rsp_valid,
    input logic [DATA_W-1:0]            mem_rsp_data,
    input logic [WAYS-1:0]              match_vec,
    input logic [WAYS-1:0][AGE_W-1:0]   set_ages,
    input cache_sa_pkg::ctrl_state_e    cur_state
);

    import cache_sa_pkg::*;

    logic [WAYS-1:0] age_seen;
    always_comb begin
        age_seen = '0;
        for (int w = 0; w < WAYS; w++) begin
            age_seen[set_ages[w]] = 1'b1;
        end
    end

    AST_READY_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid)); // R8

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8

    AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9

    AST_MEMADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00)); // R3

    AST_FILL_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_FILL && mem_rsp_valid) |-> (rsp_valid && rsp_data == mem_rsp_data)); // R3

    AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_LOOKUP && rsp_valid) |=> !mem_req_valid); // R2

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match_vec) <= 1); // R10

    AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(age_seen) == WAYS); // R5

endmodule

bind cache_sa4 cache_sa4_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .WAYS  (WAYS),
    .AGE_W (AGE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .match_vec    (match_vec),
    .set_ages     (set_ages),
    .cur_state    (cur_state)
);

// File: tb/tb_cache_sa4.sv
`timescale 1ns/1ps
module tb_cache_sa4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int mem_reads = 0;
    int mem_lat   = 1;
    int mem_stall = 0;
    logic [31:0] last_mem_addr = '0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    cache_sa4 dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] mk(input int tag, input int set, input int ofs);
        return {tag[21:0], set[7:0], ofs[1:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Backing memory model, driven at the falling edge
    bit          seen_valid = 1'b0;
    logic [31:0] seen_addr  = '0;
    bit          pend = 1'b0;
    int          pend_cnt = 0;
    logic [31:0] pend_addr = '0;
    int          stall_left = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            pend = 1'b0;
            seen_valid = 1'b0;
            stall_left = mem_stall;
        end else begin
            mem_rsp_valid = 1'b0;
            if (seen_valid && !mem_req_ready) begin
                chk(mem_req_valid && mem_req_addr == seen_addr, "R9",
                    "held backing request", mem_req_addr, seen_addr);
            end
            if (seen_valid && mem_req_ready) begin
                mem_reads++;
                last_mem_addr = seen_addr;
                pend = 1'b1;
                pend_cnt = mem_lat;
                pend_addr = seen_addr;
                stall_left = mem_stall;
            end else if (pend) begin
                if (pend_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = word_of(pend_addr);
                    pend = 1'b0;
                end else begin
                    pend_cnt--;
                end
            end
            seen_valid = mem_req_valid;
            seen_addr  = mem_req_addr;
            if (mem_req_valid && !pend) begin
                if (stall_left > 0) begin
                    mem_req_ready = 1'b0;
                    stall_left--;
                end else begin
                    mem_req_ready = 1'b1;
                end
            end else begin
                mem_req_ready = 1'b0;
            end
        end
    end

    // One request: checks data, backing-read count, address, latency, ready
    task automatic access(input logic [31:0] a, input bit exp_miss, input string req);
        int cyc = 0;
        int reads0;
        bit got = 1'b0;
        bit busy_ok = 1'b1;
        logic [31:0] data = '0;
        @(negedge clk); #1;
        chk(req_ready == 1'b1, "R8", "ready when idle", {31'b0, req_ready}, 32'd1);
        reads0 = mem_reads;
        req_valid = 1'b1;
        req_addr  = a;
        while (!got && cyc < 100) begin
            @(negedge clk); #1;
            req_valid = 1'b0;
            cyc++;
            if (req_ready) busy_ok = 1'b0;
            if (rsp_valid) begin
                got = 1'b1;
                data = rsp_data;
            end
        end
        chk(got, req, "response seen", {31'b0, got}, 32'd1);
        chk(data == word_of(a), req, "response data", data, word_of(a));
        chk(busy_ok, "R8", "ready low while busy", {31'b0, busy_ok}, 32'd1);
        if (exp_miss) begin
            chk(mem_reads - reads0 == 1, req, "one backing read on miss",
                32'(mem_reads - reads0), 32'd1);
            chk(last_mem_addr == {a[31:2], 2'b00}, "R3", "backing address",
                last_mem_addr, {a[31:2], 2'b00});
        end else begin
            chk(mem_reads == reads0, req, "no backing read on hit",
                32'(mem_reads - reads0), 32'd0);
            chk(cyc == 1, "R2", "hit latency", 32'(cyc), 32'd1);
        end
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(req_ready == 1'b1, "R11", "ready after reset", {31'b0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R11", "no response after reset", {31'b0, rsp_valid}, 32'd0);
        chk(mem_req_valid == 1'b0, "R11", "no backing read after reset",
            {31'b0, mem_req_valid}, 32'd0);
        access(mk(3, 200, 0), 1'b1, "R11");
    endtask

    task automatic t_split();
        mem_lat = 2;
        access(mk(5, 40, 0), 1'b1, "R3");
        access(mk(5, 40, 3), 1'b0, "R1");
        access(mk(5, 40, 1), 1'b0, "R2");
        access(mk(5, 40, 0) ^ 32'h0000_0200, 1'b1, "R1");
        access(mk(5, 40, 0) ^ 32'h0000_0400, 1'b1, "R1");
        access(mk(5, 40, 2), 1'b0, "R1");
        access(mk(5, 40, 0) ^ 32'h0000_0400, 1'b0, "R1");
    endtask

    task automatic t_pingpong();
        for (int i = 0; i < 8; i++) begin
            access(mk(i % 2, 0, 0), (i < 2), "R6");
        end
    endtask

    task automatic t_fill_evict();
        for (int t = 10; t < 14; t++) access(mk(t, 9, 0), 1'b1, "R4");
        for (int t = 10; t < 14; t++) access(mk(t, 9, 0), 1'b0, "R4");
        access(mk(14, 9, 0), 1'b1, "R5");
        access(mk(11, 9, 0), 1'b0, "R5");
        access(mk(12, 9, 0), 1'b0, "R5");
        access(mk(13, 9, 0), 1'b0, "R5");
        access(mk(14, 9, 0), 1'b0, "R10");
        access(mk(10, 9, 0), 1'b1, "R5");
        access(mk(12, 9, 0), 1'b0, "R10");
        access(mk(11, 9, 0), 1'b1, "R5");
    endtask

    task automatic t_reorder();
        mem_stall = 3;
        mem_lat   = 0;
        for (int t = 1; t < 5; t++) access(mk(t, 20, 0), 1'b1, "R9");
        access(mk(1, 20, 0), 1'b0, "R5");
        access(mk(5, 20, 0), 1'b1, "R5");
        access(mk(2, 20, 0), 1'b1, "R5");
        access(mk(1, 20, 0), 1'b0, "R5");
        access(mk(4, 20, 0), 1'b0, "R5");
        access(mk(5, 20, 0), 1'b0, "R10");
        access(mk(3, 20, 0), 1'b1, "R5");
        mem_stall = 0;
        mem_lat   = 3;
    endtask

    task automatic t_sets();
        access(mk(7, 30, 0), 1'b1, "R7");
        for (int t = 0; t < 6; t++) access(mk(40 + t, 31, 0), 1'b1, "R7");
        access(mk(7, 30, 0), 1'b0, "R7");
        access(mk(45, 31, 0), 1'b0, "R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_split();
        t_pingpong();
        t_fill_evict();
        t_reorder();
        t_sets();
        repeat (2) @(negedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule